// File: doc/BRIEF.md
# I2C Master SCL Phase and Setup-Delay Generator

This block paces the serial clock of an I2C master from the reference clock. A 16-bit count N, taken from the lower half of a 32-bit rate word, sets the length of one count period in reference cycles. The two-bit speed selection decides how many count periods each SCL half takes. In standard timing the low half and the high half each last one period, so the SCL period is 2·N cycles. In the two fast selections the low half lasts two periods and the high half one, so the SCL period is 3·N cycles.

The block drives SCL low only during the low half and releases it for the rest of the time. It watches the line through `sclIn`. If a target holds the released line low, the high-half count is frozen. Once the line is seen high again, the block waits a programmed setup delay. It then pulses `launchStrobe` and finishes the rest of the high half.

The bit shifter uses the single-cycle strobes that mark the start of each half and the post-stretch launch point. `sclIn` must already be synchronised to `clk`. The configuration inputs should only change while the rate count is zero.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclDriveLow`, `sclLowStrobe`, `sclHighStrobe` and `launchStrobe` are all 0.
- R2: When `baudReg[15:0]` is zero at a clock edge, from the next cycle SCL is released and no strobe is issued for as long as the count stays zero. This includes a count dropped to zero in the middle of a low half.
- R3: With `speedMode` = 0 (standard), the low half lasts N cycles and the high half N cycles. N = 1 gives one cycle each.
- R4: With `speedMode` = 1 or 3 (fast and fast-plus), the low half lasts 2·N cycles and the high half N cycles.
- R5: `speedMode` = 2 (high speed, not supported here) produces standard timing from `baudReg[15:0]`.
- R6: `baudReg[31:16]` has no effect on the SCL timing.
- R7: While SCL is released but `sclIn` reads 0 (stretching), the high-half count holds, SCL stays released and no low-half start occurs.
- R8: After a stretch, `launchStrobe` pulses for exactly one cycle, S+1 cycles after the first cycle in which `sclIn` is seen high. S is `setupReg[31:16]`, and S = 0 still waits one cycle.
- R9: `setupReg[15:0]` has no effect on the setup delay.
- R10: After the launch pulse the high half resumes from its held count. When the stretch started in the first high cycle, the next low half starts S+2+N cycles after the release cycle.
- R11: `sclLowStrobe` marks the first cycle in which SCL is driven low and `sclHighStrobe` the first released cycle after a low half. At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedMode | input | 2 | 0 standard, 1 fast, 2 high speed (treated as standard), 3 fast-plus |
| baudReg | input | 32 | Rate word; bits 15:0 hold N, bits 31:16 are unused here |
| setupReg | input | 32 | Setup word; bits 31:16 hold S |
| sclIn | input | 1 | Synchronised level of the SCL line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sclLowStrobe | output | 1 | One-cycle pulse in the first low cycle of each period |
| sclHighStrobe | output | 1 | One-cycle pulse in the first released cycle after a low half |
| launchStrobe | output | 1 | One-cycle pulse when the post-stretch setup delay expires |

## Verification
On every cycle, the bound assertions check these relations:
- SCL is released with no strobes while the count is zero.
- Each strobe matches the SCL edge it marks.
- A released line that reads low never leads straight into a low half.
- The launch pulse is single-cycle and exclusive with the other strobes.

Only the directed scenarios can show the actual phase lengths for each speed selection, that the unused register halves are ignored, the exact S+1 delay after release, and where the resumed high half ends.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_SETUP
  } genState_t;

  typedef struct packed {
    logic phaseClr;
    logic phaseInc;
    logic setupClr;
    logic setupInc;
  } ctlStrobe_t;

  typedef struct packed {
    logic baudZero;
    logic lowDone;
    logic highDone;
    logic setupDone;
  } dpStatus_t;

endpackage

// File: rtl/i2c_scl_timer_datapath.sv
module i2c_scl_timer_datapath
  import i2c_scl_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SETUP_W   = 16,
  parameter int SETUP_LSB = 16,
  parameter int REG_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastSel,
  input  logic [CNT_W-1:0] baseCnt,
  input  logic [REG_W-1:0] setupReg,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        stat
);

  localparam int PH_W = CNT_W + 1;

  logic [PH_W-1:0]    phaseCnt;
  logic [SETUP_W-1:0] setupCnt;
  logic [PH_W-1:0]    lowLen;
  logic [PH_W-1:0]    highLen;
  logic [SETUP_W-1:0] setupLen;

  // Fast selections stretch the low half to two count periods.
  assign lowLen   = fastSel ? {baseCnt, 1'b0} : {1'b0, baseCnt};
  assign highLen  = {1'b0, baseCnt};
  assign setupLen = setupReg[SETUP_LSB +: SETUP_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.phaseClr) begin
      phaseCnt <= '0;
    end else if (ctl.phaseInc) begin
      phaseCnt <= phaseCnt + PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupCnt <= '0;
    end else if (ctl.setupClr) begin
      setupCnt <= '0;
    end else if (ctl.setupInc) begin
      setupCnt <= setupCnt + SETUP_W'(1);
    end
  end

  always_comb begin
    stat.baudZero  = (baseCnt == '0);
    stat.lowDone   = (phaseCnt >= lowLen - PH_W'(1));
    stat.highDone  = (phaseCnt >= highLen - PH_W'(1));
    stat.setupDone = (setupCnt >= setupLen);
  end

endmodule

// File: rtl/i2c_scl_timer_ctrl.sv
module i2c_scl_timer_ctrl
  import i2c_scl_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output genState_t  state,
  output logic       sclDriveLow,
  output logic       lowStrobe,
  output logic       highStrobe,
  output logic       launch
);

  genState_t nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (stat.baudZero) begin
      nextState    = ST_IDLE;
      ctl.phaseClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState    = ST_LOW;
          ctl.phaseClr = 1'b1;
        end
        ST_LOW: begin
          if (stat.lowDone) begin
            nextState    = ST_HIGH;
            ctl.phaseClr = 1'b1;
          end else begin
            ctl.phaseInc = 1'b1;
          end
        end
        ST_HIGH: begin
          if (!sclIn) begin
            nextState = ST_HOLD;
          end else if (stat.highDone) begin
            nextState    = ST_LOW;
            ctl.phaseClr = 1'b1;
          end else begin
            ctl.phaseInc = 1'b1;
          end
        end
        ST_HOLD: begin
          if (sclIn) begin
            nextState    = ST_SETUP;
            ctl.setupClr = 1'b1;
          end
        end
        ST_SETUP: begin
          if (stat.setupDone) begin
            nextState = ST_HIGH;
          end else begin
            ctl.setupInc = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lowStrobe  <= 1'b0;
      highStrobe <= 1'b0;
    end else begin
      state      <= nextState;
      lowStrobe  <= (nextState == ST_LOW) && (state != ST_LOW);
      highStrobe <= (state == ST_LOW) && (nextState == ST_HIGH);
    end
  end

  assign sclDriveLow = (state == ST_LOW);
  assign launch      = (state == ST_SETUP) && stat.setupDone && !stat.baudZero;

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SETUP_W   = 16,
  parameter int SETUP_LSB = 16,
  parameter int REG_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       speedMode,
  input  logic [REG_W-1:0] baudReg,
  input  logic [REG_W-1:0] setupReg,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sclLowStrobe,
  output logic             sclHighStrobe,
  output logic             launchStrobe
);

  ctlStrobe_t ctl;
  dpStatus_t  stat;
  genState_t  ctlState;
  logic       fastSel;
  logic       unusedBits;

  // Selections 1 and 3 are the fast ones; 2 falls back to standard.
  assign fastSel    = speedMode[0];
  assign unusedBits = ^{speedMode[1], baudReg[REG_W-1:CNT_W]};

  i2c_scl_timer_datapath #(
    .CNT_W    (CNT_W),
    .SETUP_W  (SETUP_W),
    .SETUP_LSB(SETUP_LSB),
    .REG_W    (REG_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .fastSel (fastSel),
    .baseCnt (baudReg[CNT_W-1:0]),
    .setupReg(setupReg),
    .ctl     (ctl),
    .stat    (stat)
  );

  i2c_scl_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .stat       (stat),
    .ctl        (ctl),
    .state      (ctlState),
    .sclDriveLow(sclDriveLow),
    .lowStrobe  (sclLowStrobe),
    .highStrobe (sclHighStrobe),
    .launch     (launchStrobe)
  );

endmodule

// File: rtl/i2c_scl_timer_checker.sv
module i2c_scl_timer_checker
  import i2c_scl_timer_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      baudZero,
  input logic      sclIn,
  input logic      sclDriveLow,
  input logic      lowS,
  input logic      highS,
  input logic      launch,
  input genState_t st
);

  p_zero_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    baudZero |=> (!sclDriveLow && !lowS && !highS && !launch));

  p_low_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> lowS);

  p_low_mark_r11: assert property (@(posedge clk) disable iff (!rstN)
    lowS |-> sclDriveLow);

  p_high_mark_r11: assert property (@(posedge clk) disable iff (!rstN)
    highS |-> (!sclDriveLow && $past(sclDriveLow)));

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && !sclDriveLow && !sclIn) |=> !sclDriveLow);

  p_launch_place_r8: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> (st == ST_SETUP && !sclDriveLow));

  p_launch_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lowS, highS, launch}));

endmodule

bind i2c_scl_timer i2c_scl_timer_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .baudZero   (baudReg[CNT_W-1:0] == '0),
  .sclIn      (sclIn),
  .sclDriveLow(sclDriveLow),
  .lowS       (sclLowStrobe),
  .highS      (sclHighStrobe),
  .launch     (launchStrobe),
  .st         (ctlState)
);

// File: tb/test_i2c_scl_timer.sv
module test_i2c_scl_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  speedMode = 2'd0;
  logic [31:0] baudReg = '0;
  logic [31:0] setupReg = '0;
  logic        slaveHold = 1'b0;
  logic        sclIn;
  logic        sclDriveLow;
  logic        sclLowStrobe;
  logic        sclHighStrobe;
  logic        launchStrobe;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  // Wired-AND line: low if the master pulls or the target holds.
  assign sclIn = ~sclDriveLow & ~slaveHold;

  i2c_scl_timer i_i2c_scl_timer (
    .clk          (clk),
    .rstN         (rstN),
    .speedMode    (speedMode),
    .baudReg      (baudReg),
    .setupReg     (setupReg),
    .sclIn        (sclIn),
    .sclDriveLow  (sclDriveLow),
    .sclLowStrobe (sclLowStrobe),
    .sclHighStrobe(sclHighStrobe),
    .launchStrobe (launchStrobe)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] mode, input logic [31:0] baud,
                           input logic [31:0] setup);
    baudReg = '0;
    step();
    step();
    speedMode = mode;
    setupReg  = setup;
    baudReg   = baud;
  endtask

  task automatic measure(input int expLow, input int expHigh, input string req);
    int lowN;
    int highN;
    while (!sclLowStrobe) step();
    lowN = 0;
    do begin
      lowN++;
      step();
    end while (sclDriveLow);
    check(sclHighStrobe == 1'b1, {req, " high mark"}, int'(sclHighStrobe), 1);
    highN = 0;
    do begin
      highN++;
      step();
    end while (!sclDriveLow);
    check(sclLowStrobe == 1'b1, {req, " low mark"}, int'(sclLowStrobe), 1);
    check(lowN == expLow, {req, " low length"}, lowN, expLow);
    check(highN == expHigh, {req, " high length"}, highN, expHigh);
  endtask

  task automatic t_reset();
    step();
    check({sclDriveLow, sclLowStrobe, sclHighStrobe, launchStrobe} == 4'b0,
          "R1 outputs in reset", int'({sclDriveLow, sclLowStrobe, sclHighStrobe, launchStrobe}), 0);
    rstN = 1'b1;
    step();
    check({sclDriveLow, sclLowStrobe, sclHighStrobe, launchStrobe} == 4'b0,
          "R1 outputs after reset", int'({sclDriveLow, sclLowStrobe, sclHighStrobe, launchStrobe}), 0);
  endtask

  task automatic t_standard();
    configure(2'd0, 32'h0000_0004, '0);
    measure(4, 4, "R3 N=4");
    configure(2'd0, 32'h0000_0001, '0);
    measure(1, 1, "R3 N=1");
  endtask

  task automatic t_fast();
    configure(2'd1, 32'h0000_0003, '0);
    measure(6, 3, "R4 fast N=3");
    configure(2'd3, 32'h0000_0002, '0);
    measure(4, 2, "R4 fast-plus N=2");
  endtask

  task automatic t_high_speed_fallback();
    configure(2'd2, 32'h0002_0005, '0);
    measure(5, 5, "R5 mode 2");
  endtask

  task automatic t_high_half();
    configure(2'd0, 32'hFFFF_0003, '0);
    measure(3, 3, "R6 upper half set");
  endtask

  task automatic t_stretch(input int n, input logic [31:0] setup, input int s,
                           input string req);
    int badLaunch;
    int lowAt;
    bit pulled;
    configure(2'd0, n, setup);
    while (!sclHighStrobe) step();
    slaveHold = 1'b1;
    pulled = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (sclDriveLow || sclLowStrobe) pulled = 1'b1;
    end
    check(!pulled, "R7 released during stretch", int'(pulled), 0);
    slaveHold = 1'b0;
    badLaunch = 0;
    lowAt = -1;
    for (int k = 1; k <= s + 2 + n; k++) begin
      step();
      if (k == s + 1)
        check(launchStrobe == 1'b1, {req, " R8 launch delay"}, int'(launchStrobe), 1);
      else if (launchStrobe)
        badLaunch++;
      if (sclLowStrobe && lowAt < 0) lowAt = k;
    end
    check(badLaunch == 0, {req, " R8 single launch"}, badLaunch, 0);
    check(lowAt == s + 2 + n, {req, " R10 resume length"}, lowAt, s + 2 + n);
  endtask

  task automatic t_zero_drop();
    int stray;
    configure(2'd0, 32'h0000_0006, '0);
    while (!sclLowStrobe) step();
    step();
    baudReg = '0;
    step();
    check(sclDriveLow == 1'b0, "R2 release after drop", int'(sclDriveLow), 0);
    stray = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (sclDriveLow || sclLowStrobe || sclHighStrobe || launchStrobe) stray++;
    end
    check(stray == 0, "R2 quiet while zero", stray, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_standard();
    t_fast();
    t_high_speed_fallback();
    t_high_half();
    t_stretch(4, 32'h0003_0000, 3, "S=3");
    t_stretch(3, 32'h0000_FFFF, 0, "R9 S=0 low bits set");
    t_zero_drop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule